// File: doc/BRIEF.md
# Dual-Select Byte-Lane Static Memory

A word-organised static memory with a 16-bit word split into a lower and an upper byte lane. Two chip selects of opposite polarity, an active-low output enable, an active-low write enable and one active-low enable per byte lane decide, lane by lane, whether that lane is written, driven for a read, or left floating. The bidirectional data bus is split into a write-data input, a read-data output and one drive-enable bit per lane, which the surrounding pad logic uses to steer the shared bus.

The control pins are sampled by a free-running clock. A lane is written when its write-qualify condition, sampled true on one rising edge, is found false on a later one. The data and address stored are the ones sampled on the last edge where the condition held. So a write can be ended by either chip select, by the write enable, or by the lane's own enable. The depth is set by an address-width parameter, kept small for simulation.

Top module: `dss_sram`

## Requirements
- R1: The block is selected only while sel_n_i is 0 and sel_i is 1. Otherwise both lanes float (rdata_oe_o is 2'b00) and no lane is written, whatever the address, data and other control pins show.
- R2: ben_ni[0] governs lane 0 (data bits 7:0) and ben_ni[1] governs lane 1 (bits 15:8). A lane whose enable is 1 during a write keeps its earlier contents.
- R3: A lane's write-qualify condition is: selected, we_ni at 0 and that lane's enable at 0. The lane is written at the first rising edge that samples the condition false after one that sampled it true. It stores wdata_i and addr_i as sampled on the last edge where the condition held. Any of the four pins may end the write.
- R4: Lane l is driven (rdata_oe_o[l] = 1) only while the block is selected, we_ni is 1, oe_ni is 0 and ben_ni[l] is 0, and no write is awaiting commit. A driven lane shows the stored byte at addr_i.
- R5: With oe_ni at 1, or with both lane enables at 1, both lanes float.
- R6: While the block is selected with we_ni at 0, no lane is driven, even with oe_ni at 0. No lane is driven in the cycle between the end of a write and its commit edge.
- R7: A lane that is not driven reads 0 on its bits of rdata_o.
- R8: The memory holds 2**ADDR_W independent words, from address 0 up to the highest address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock for the control pins |
| rst_ni | input | 1 | Active-low asynchronous reset; drops any write in flight |
| addr_i | input | ADDR_W | Word address |
| sel_n_i | input | 1 | Chip select, active low |
| sel_i | input | 1 | Chip select, active high |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| ben_ni | input | 2 | Lane enables, active low; bit 0 lower byte, bit 1 upper byte |
| wdata_i | input | 16 | Data in from the shared bus |
| rdata_o | output | 16 | Data out to the shared bus, 0 on undriven lanes |
| rdata_oe_o | output | 2 | Per-lane bus drive enable |

## Verification
On every cycle the assertions check that the block drives no lane while it is deselected, while output enable is high, while a write is active or awaiting commit, or while that lane's enable is high. They also check that undriven lanes read zero and that driven read data holds steady while the address holds. Only the bench scenarios can show that a write lands in the right lane and word. These cover each of the four ways to end a write, byte-masked writes that must leave the other lane untouched, writes attempted in standby, and addresses at both ends of the array.

// File: rtl/dss_pkg.sv
package dss_pkg;
  localparam int LANE_W = 8;
  localparam int LANES  = 2;
  localparam int WORD_W = LANE_W * LANES;
  typedef logic [LANE_W-1:0] lane_t;
endpackage

// File: rtl/dss_ctrl.sv
module dss_ctrl #(
  parameter int LANES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_n_i,
  input  logic             sel_i,
  input  logic             we_ni,
  input  logic             oe_ni,
  input  logic [LANES-1:0] ben_ni,
  output logic [LANES-1:0] qual_o,
  output logic [LANES-1:0] commit_o,
  output logic [LANES-1:0] drive_o
);
  logic             selected;
  logic             pending;
  logic [LANES-1:0] qual_q;

  assign selected = ~sel_n_i & sel_i;
  assign qual_o   = {LANES{selected & ~we_ni}} & ~ben_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) qual_q <= '0;
    else         qual_q <= qual_o;
  end

  // falling edge of the sampled qualify condition commits the lane
  assign commit_o = qual_q & ~qual_o;
  assign pending  = |qual_q;
  assign drive_o  = {LANES{selected & we_ni & ~oe_ni & ~pending}} & ~ben_ni;
endmodule

// File: rtl/dss_lane.sv
module dss_lane #(
  parameter int ADDR_W = 6,
  parameter int W      = 8
) (
  input  logic              clk_i,
  input  logic              qual_i,
  input  logic              commit_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [W-1:0]      rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] data_q;

  always_ff @(posedge clk_i) begin
    if (qual_i) data_q <= wdata_i;
  end

  always_ff @(posedge clk_i) begin
    if (commit_i) mem[waddr_i] <= data_q;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/dss_sram.sv
module dss_sram #(
  parameter int ADDR_W = 6
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic                         sel_n_i,
  input  logic                         sel_i,
  input  logic                         we_ni,
  input  logic                         oe_ni,
  input  logic [dss_pkg::LANES-1:0]    ben_ni,
  input  logic [dss_pkg::WORD_W-1:0]   wdata_i,
  output logic [dss_pkg::WORD_W-1:0]   rdata_o,
  output logic [dss_pkg::LANES-1:0]    rdata_oe_o
);
  import dss_pkg::*;

  logic [LANES-1:0] qual, commit, drive;
  logic [ADDR_W-1:0] addr_q;

  dss_ctrl #(.LANES(LANES)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_n_i (sel_n_i),
    .sel_i   (sel_i),
    .we_ni   (we_ni),
    .oe_ni   (oe_ni),
    .ben_ni  (ben_ni),
    .qual_o  (qual),
    .commit_o(commit),
    .drive_o (drive)
  );

  // write address follows the last edge on which any lane qualified
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    addr_q <= '0;
    else if (|qual) addr_q <= addr_i;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    lane_t rd;
    dss_lane #(.ADDR_W(ADDR_W), .W(LANE_W)) u_lane (
      .clk_i   (clk_i),
      .qual_i  (qual[l]),
      .commit_i(commit[l]),
      .waddr_i (addr_q),
      .wdata_i (wdata_i[l*LANE_W +: LANE_W]),
      .raddr_i (addr_i),
      .rdata_o (rd)
    );
    assign rdata_o[l*LANE_W +: LANE_W] = drive[l] ? rd : '0;
  end

  assign rdata_oe_o = drive;
endmodule

// File: rtl/dss_sram_chk.sv
module dss_sram_chk #(
  parameter int ADDR_W = 6
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [ADDR_W-1:0]          addr_i,
  input logic                       sel_n_i,
  input logic                       sel_i,
  input logic                       we_ni,
  input logic                       oe_ni,
  input logic [dss_pkg::LANES-1:0]  ben_ni,
  input logic [dss_pkg::WORD_W-1:0] rdata_o,
  input logic [dss_pkg::LANES-1:0]  rdata_oe_o
);
  import dss_pkg::*;

  a_r1_standby_float: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!sel_n_i && sel_i) |-> rdata_oe_o == '0);

  a_r4_lane_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rdata_oe_o) |-> (rdata_oe_o & ben_ni) == '0);

  a_r4_read_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|rdata_oe_o) && $stable(rdata_oe_o) && $stable(addr_i)) |-> $stable(rdata_o));

  a_r5_oe_high_float: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> rdata_oe_o == '0);

  a_r6_write_float: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_ni |-> rdata_oe_o == '0);

  a_r6_commit_float: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!sel_n_i && sel_i && !we_ni && (ben_ni != '1)) |-> rdata_oe_o == '0);

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    a_r7_float_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rdata_oe_o[l] |-> rdata_o[l*LANE_W +: LANE_W] == '0);
  end
endmodule

bind dss_sram dss_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .sel_n_i   (sel_n_i),
  .sel_i     (sel_i),
  .we_ni     (we_ni),
  .oe_ni     (oe_ni),
  .ben_ni    (ben_ni),
  .rdata_o   (rdata_o),
  .rdata_oe_o(rdata_oe_o)
);

// File: tb/dss_sram_tb.sv
module dss_sram_tb;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          sel_n_i = 1'b1, sel_i = 1'b0, we_ni = 1'b1, oe_ni = 1'b1;
  logic [1:0]    ben_ni = 2'b11;
  logic [15:0]   wdata_i = '0;
  logic [15:0]   rdata_o;
  logic [1:0]    rdata_oe_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] shadow [DEPTH];

  typedef struct {logic [1:0] oe; logic [15:0] d; string tag;} exp_t;
  exp_t sb [$];
  exp_t e;

  always #4 clk_i = ~clk_i;

  dss_sram #(.ADDR_W(AW)) u_dut (
    .clk_i, .rst_ni, .addr_i, .sel_n_i, .sel_i, .we_ni, .oe_ni,
    .ben_ni, .wdata_i, .rdata_o, .rdata_oe_o
  );

  // monitor: compare one expected item per cycle, away from the edge
  always @(negedge clk_i) begin
    if (sb.size() > 0) begin
      e = sb.pop_front();
      checks++;
      if (rdata_oe_o !== e.oe || rdata_o !== e.d) begin
        errors++;
        $display("FAIL %s: oe=%b data=%h expected oe=%b data=%h",
                 e.tag, rdata_oe_o, rdata_o, e.oe, e.d);
      end
    end
  end

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic push(input logic [1:0] oe, input logic [15:0] d, input string tag);
    exp_t x;
    x.oe = oe; x.d = d; x.tag = tag;
    sb.push_back(x);
  endtask

  task automatic idle();
    sel_n_i = 1'b1; sel_i = 1'b0; we_ni = 1'b1; oe_ni = 1'b1; ben_ni = 2'b11;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [1:0] ben, input string tag);
    logic [15:0] m;
    step();
    sel_n_i = 1'b0; sel_i = 1'b1; we_ni = 1'b1; oe_ni = 1'b0; ben_ni = ben; addr_i = a;
    m = {{8{~ben[1]}}, {8{~ben[0]}}};
    push(~ben, shadow[a] & m, tag);
  endtask

  // mode: 0 ends on we, 1 on sel_n, 2 on sel, 3 on lane enables
  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d,
                    input logic [1:0] ben, input int mode, input string tag);
    step();
    sel_n_i = 1'b0; sel_i = 1'b1; we_ni = 1'b0; oe_ni = 1'b0; ben_ni = ben;
    addr_i = a; wdata_i = d;
    push(2'b00, 16'h0, {tag, " R6 write float"});
    step();
    step();
    case (mode)
      0: we_ni = 1'b1;
      1: sel_n_i = 1'b1;
      2: sel_i = 1'b0;
      default: ben_ni = 2'b11;
    endcase
    addr_i = ~a; wdata_i = ~d;
    push(2'b00, 16'h0, {tag, " R6 commit float"});
    if (!ben[0]) shadow[a][7:0]  = d[7:0];
    if (!ben[1]) shadow[a][15:8] = d[15:8];
    step();
    idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) shadow[i] = '0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    push(2'b00, 16'h0, "R1 reset idle float");
    // first write to each used word covers both lanes so the shadow is defined
    wr(5, 16'hA1B2, 2'b00, 0, "R3 we-ended");
    rd(5, 2'b00, "R4 both lanes read");
    wr(5, 16'h77CC, 2'b10, 1, "R3 sel_n-ended");
    rd(5, 2'b00, "R2 lower-only write keeps upper");
    wr(5, 16'hEE33, 2'b01, 2, "R3 sel-ended");
    rd(5, 2'b00, "R2 upper-only write keeps lower");
    wr(9, 16'h1234, 2'b00, 3, "R3 enable-ended");
    rd(9, 2'b00, "R3 enable-ended data");
    rd(9, 2'b10, "R4 lower-only read");
    rd(9, 2'b01, "R4 upper-only read R7");
    step(); sel_n_i = 1'b0; sel_i = 1'b1; we_ni = 1'b1; oe_ni = 1'b1; ben_ni = 2'b00;
    push(2'b00, 16'h0, "R5 oe high float");
    step(); oe_ni = 1'b0; ben_ni = 2'b11;
    push(2'b00, 16'h0, "R5 both enables high float");
    step(); sel_n_i = 1'b1; ben_ni = 2'b00;
    push(2'b00, 16'h0, "R1 sel_n high float");
    step(); sel_n_i = 1'b0; sel_i = 1'b0;
    push(2'b00, 16'h0, "R1 sel low float");
    // write attempts in standby must be ignored
    step(); sel_n_i = 1'b1; sel_i = 1'b1; we_ni = 1'b0; addr_i = 9; wdata_i = 16'hDEAD;
    push(2'b00, 16'h0, "R1 standby write float");
    step(); sel_n_i = 1'b0; sel_i = 1'b0;
    push(2'b00, 16'h0, "R1 standby write float");
    step(); we_ni = 1'b1;
    step(); idle();
    rd(9, 2'b00, "R1 standby write ignored");
    wr(DEPTH-1, 16'hBEEF, 2'b00, 0, "R8 top");
    wr(0, 16'h5555, 2'b00, 0, "R8 bottom");
    rd(DEPTH-1, 2'b00, "R8 top address");
    rd(0, 2'b00, "R8 bottom address");
    for (int i = 16; i < 24; i++)
      wr(i, 16'h0101 * i ^ 16'hF00F, 2'b00, i % 4, "R3 pattern");
    for (int i = 16; i < 24; i++) rd(i, 2'b00, "R8 pattern readback");
    step(); idle();
    step();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule